// File: doc/BRIEF.md
# Descriptor Write-Mask Register

This block holds a 128-bit write mask used when a translation descriptor is updated by a read-check-write operation. Software reaches the register in two ways. A 64-bit access reads or writes only the low half. A paired 128-bit access reads or writes the whole register, and it exists only when the wide-descriptor strap is high. Bits that the mask layout reserves are never stored and always read as zero. Two strap inputs for optional features make more of the upper bits reserved when those features are absent.

The datapath does not use the stored value directly. It derives two effective masks from it. In the 128-bit descriptor mask, a single stored bit fans out across a wide span, and fixed holes are forced to zero. In the 64-bit descriptor mask, a different single bit fans out across a different span. A merge port takes an old descriptor and new data and combines them under the effective mask for the width selected on that port.

Top module: `desc_mask_reg`

## Requirements
- R1: A 64-bit write (`lo_wr_i`) loads `wdata_i[63:0]` into stored bits 63:0 on the next clock edge and leaves stored bits 127:64 unchanged. `rd_lo_o` always equals `rd_full_o[63:0]`.
- R2: A 128-bit write (`full_wr_i`) loads all 128 bits only while `strap_wide_i` is 1. While `strap_wide_i` is 0 the 128-bit write is ignored. When both writes are asserted in the same cycle with `strap_wide_i` at 1, the 128-bit write wins.
- R3: Stored bits 0, 18 to 49 and 52 always read as zero, and writes to them are discarded. With `strap_wide_i` at 1, bits 64 to 90, 101 to 107, 114, 119, 120, 125 and 126 are also reserved. With `strap_wide_i` at 0, all of bits 127:64 read as zero.
- R4: With `strap_feat_a_i` at 0, bits 121 to 124 are reserved. With `strap_feat_b_i` at 0, bit 108 is reserved. In both cases those bits read as zero and their write data is discarded.
- R5: In `eff128_o`, every bit from 17 to 55 equals stored bit 16.
- R6: In `eff128_o`, bits 0, 1, 56 to 90, 101 to 107, 114, 119, 120, 125 and 126 are zero. Bits 121 to 124 are zero without feature A, and bit 108 is zero without feature B. Every other bit equals the stored bit. The whole of `eff128_o` is zero while `strap_wide_i` is 0.
- R7: In `eff64_o`, every bit from 18 to 49 equals stored bit 17. Every other bit equals the stored bit.
- R8: `merge_o` = (`merge_old_i` & ~m) | (`merge_new_i` & m). Here m is `eff128_o` when `merge_wide_i` is 1, and `eff64_o` zero-extended to 128 bits when `merge_wide_i` is 0. In the zero-extended case the upper half of the result passes `merge_old_i` through.
- R9: Reset (active-low `rst_ni`) clears every stored bit to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_wide_i | input | 1 | 128-bit descriptor support strap |
| strap_feat_a_i | input | 1 | Optional feature A present (bits 124:121) |
| strap_feat_b_i | input | 1 | Optional feature B present (bit 108) |
| lo_wr_i | input | 1 | 64-bit write of the low half |
| full_wr_i | input | 1 | Paired 128-bit write |
| wdata_i | input | 128 | Write data (low half only for a 64-bit write) |
| rd_lo_o | output | 64 | 64-bit read value |
| rd_full_o | output | 128 | 128-bit read value |
| eff64_o | output | 64 | Effective mask for 64-bit descriptors |
| eff128_o | output | 128 | Effective mask for 128-bit descriptors |
| merge_wide_i | input | 1 | Merge width select, 1 = 128-bit descriptor |
| merge_old_i | input | 128 | Old descriptor value |
| merge_new_i | input | 128 | New descriptor data |
| merge_o | output | 128 | Merged descriptor |

## Verification
The bench sets stored bit 16 and stored bit 17 to opposite values. A design that swapped the two fan-out sources, or their spans, would then show the wrong bits across 17 to 55 or 18 to 49. It writes all ones with each feature strap low and with the wide strap low. A reserved or feature-gated bit that leaked through would show up as a one on the read port or in a mask hole. It issues both write kinds together, and a 128-bit write with the wide strap off, to catch wrong priority and a missing gate. It also merges in both widths, where a design that failed to zero-extend the 64-bit mask would corrupt the upper half of the old descriptor.

// File: rtl/desc_mask_pkg.sv
`timescale 1ns/1ps
package desc_mask_pkg;

    localparam int unsigned DESC_W = 128;
    localparam int unsigned HALF_W = DESC_W / 2;

    // single-bit sources of the two fan-out spans
    localparam int unsigned FAN128_SRC = 16;
    localparam int unsigned FAN128_LO  = 17;
    localparam int unsigned FAN128_HI  = 55;
    localparam int unsigned FAN64_SRC  = 17;
    localparam int unsigned FAN64_LO   = 18;
    localparam int unsigned FAN64_HI   = 49;

    typedef struct packed {
        logic [DESC_W-1:0] mask;
    } mreg_t;

    function automatic bit in_span(int n, int lo, int hi);
        return (n >= lo) && (n <= hi);
    endfunction

    // reserved in the low half regardless of straps
    function automatic bit resv_lo(int n);
        return (n == 0) || (n == 52) || in_span(n, 18, 49);
    endfunction

    // reserved in the upper half when wide support is present
    function automatic bit resv_hi(int n);
        return in_span(n, 64, 90) || in_span(n, 101, 107) || (n == 114) ||
               in_span(n, 119, 120) || in_span(n, 125, 126);
    endfunction

    function automatic bit feat_a_bit(int n);
        return in_span(n, 121, 124);
    endfunction

    function automatic bit feat_b_bit(int n);
        return n == 108;
    endfunction

    // fixed holes of the 128-bit effective mask
    function automatic bit hole128(int n);
        return in_span(n, 0, 1) || in_span(n, 56, 90) || in_span(n, 101, 107) ||
               (n == 114) || in_span(n, 119, 120) || in_span(n, 125, 126);
    endfunction

endpackage

// File: rtl/desc_mask_legal.sv
`timescale 1ns/1ps
module desc_mask_legal #(
    parameter int unsigned W = desc_mask_pkg::DESC_W
) (
    input  logic         wide_i,
    input  logic         feat_a_i,
    input  logic         feat_b_i,
    output logic [W-1:0] legal_o
);
    localparam int unsigned HW = W / 2;

    for (genvar n = 0; n < W; n++) begin : g_bit
        if (n < HW) begin : g_lo
            localparam bit RESV = desc_mask_pkg::resv_lo(n);
            assign legal_o[n] = !RESV;
        end else begin : g_hi
            localparam bit RESV = desc_mask_pkg::resv_hi(n);
            localparam bit IS_A = desc_mask_pkg::feat_a_bit(n);
            localparam bit IS_B = desc_mask_pkg::feat_b_bit(n);
            assign legal_o[n] = wide_i && !RESV &&
                                (IS_A ? feat_a_i : 1'b1) &&
                                (IS_B ? feat_b_i : 1'b1);
        end
    end
endmodule

// File: rtl/desc_mask_eff.sv
`timescale 1ns/1ps
module desc_mask_eff #(
    parameter int unsigned W = desc_mask_pkg::DESC_W
) (
    input  logic [W-1:0]   stored_i,
    input  logic           wide_i,
    input  logic           feat_a_i,
    input  logic           feat_b_i,
    output logic [W/2-1:0] eff64_o,
    output logic [W-1:0]   eff128_o
);
    import desc_mask_pkg::*;
    localparam int unsigned HW = W / 2;

    // 128-bit descriptor view
    for (genvar n = 0; n < W; n++) begin : g_e128
        localparam bit FAN  = in_span(n, FAN128_LO, FAN128_HI);
        localparam bit HOLE = hole128(n);
        localparam bit IS_A = feat_a_bit(n);
        localparam bit IS_B = feat_b_bit(n);
        logic src;
        assign src = FAN ? stored_i[FAN128_SRC] : stored_i[n];
        assign eff128_o[n] = src && wide_i && !HOLE &&
                             (IS_A ? feat_a_i : 1'b1) &&
                             (IS_B ? feat_b_i : 1'b1);
    end

    // 64-bit descriptor view
    for (genvar n = 0; n < HW; n++) begin : g_e64
        localparam bit FAN = in_span(n, FAN64_LO, FAN64_HI);
        assign eff64_o[n] = FAN ? stored_i[FAN64_SRC] : stored_i[n];
    end
endmodule

// File: rtl/desc_mask_merge.sv
`timescale 1ns/1ps
module desc_mask_merge #(
    parameter int unsigned W = desc_mask_pkg::DESC_W
) (
    input  logic           sel_wide_i,
    input  logic [W/2-1:0] eff64_i,
    input  logic [W-1:0]   eff128_i,
    input  logic [W-1:0]   old_i,
    input  logic [W-1:0]   new_i,
    output logic [W-1:0]   merge_o
);
    localparam int unsigned HW = W / 2;

    logic [W-1:0] sel_mask;

    always_comb begin
        sel_mask = sel_wide_i ? eff128_i : {{HW{1'b0}}, eff64_i};
        merge_o  = (old_i & ~sel_mask) | (new_i & sel_mask);
    end
endmodule

// File: rtl/desc_mask_reg.sv
`timescale 1ns/1ps
module desc_mask_reg #(
    parameter int unsigned W = desc_mask_pkg::DESC_W
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           strap_wide_i,
    input  logic           strap_feat_a_i,
    input  logic           strap_feat_b_i,
    input  logic           lo_wr_i,
    input  logic           full_wr_i,
    input  logic [W-1:0]   wdata_i,
    output logic [W/2-1:0] rd_lo_o,
    output logic [W-1:0]   rd_full_o,
    output logic [W/2-1:0] eff64_o,
    output logic [W-1:0]   eff128_o,
    input  logic           merge_wide_i,
    input  logic [W-1:0]   merge_old_i,
    input  logic [W-1:0]   merge_new_i,
    output logic [W-1:0]   merge_o
);
    import desc_mask_pkg::*;
    localparam int unsigned HW = W / 2;

    mreg_t        st_d, st_q;
    logic [W-1:0] legal;
    logic [W-1:0] visible;

    desc_mask_legal #(.W(W)) u_legal (
        .wide_i  (strap_wide_i),
        .feat_a_i(strap_feat_a_i),
        .feat_b_i(strap_feat_b_i),
        .legal_o (legal)
    );

    always_comb begin
        st_d = st_q;
        if (full_wr_i && strap_wide_i) begin
            st_d.mask = wdata_i & legal;
        end else if (lo_wr_i) begin
            st_d.mask = {st_q.mask[W-1:HW], wdata_i[HW-1:0]} & legal;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // re-mask on read so a strap change never exposes a stale bit
    assign visible   = st_q.mask & legal;
    assign rd_full_o = visible;
    assign rd_lo_o   = visible[HW-1:0];

    desc_mask_eff #(.W(W)) u_eff (
        .stored_i(visible),
        .wide_i  (strap_wide_i),
        .feat_a_i(strap_feat_a_i),
        .feat_b_i(strap_feat_b_i),
        .eff64_o (eff64_o),
        .eff128_o(eff128_o)
    );

    desc_mask_merge #(.W(W)) u_merge (
        .sel_wide_i(merge_wide_i),
        .eff64_i   (eff64_o),
        .eff128_i  (eff128_o),
        .old_i     (merge_old_i),
        .new_i     (merge_new_i),
        .merge_o   (merge_o)
    );
endmodule

// File: rtl/desc_mask_reg_chk.sv
`timescale 1ns/1ps
module desc_mask_reg_chk (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         strap_wide_i,
    input logic         lo_wr_i,
    input logic         full_wr_i,
    input logic [127:0] wdata_i,
    input logic [63:0]  rd_lo_o,
    input logic [127:0] rd_full_o,
    input logic [63:0]  eff64_o,
    input logic [127:0] eff128_o,
    input logic         merge_wide_i,
    input logic [127:0] merge_old_i,
    input logic [127:0] merge_new_i,
    input logic [127:0] merge_o
);
    localparam logic [63:0] LO_WRITABLE = 64'hFFEC_0000_0003_FFFE;

    logic [127:0] chk_sel;
    assign chk_sel = merge_wide_i ? eff128_o : {64'b0, eff64_o};

    a_r1_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_wr_i && !(full_wr_i && strap_wide_i)) |=>
        (rd_full_o[127:64] == $past(rd_full_o[127:64])));

    a_r1_lo_loaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lo_wr_i && !(full_wr_i && strap_wide_i)) |=>
        (rd_lo_o == ($past(wdata_i[63:0]) & LO_WRITABLE)));

    a_r2_full_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_wr_i && !strap_wide_i && !lo_wr_i) |=> $stable(rd_full_o));

    a_r3_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_full_o[0] == 1'b0) && (rd_full_o[52] == 1'b0) && (rd_full_o[49:18] == '0) &&
        (strap_wide_i || rd_full_o[127:64] == '0));

    a_r5_fan128: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strap_wide_i |-> (eff128_o[55:17] == {39{rd_full_o[16]}}));

    a_r6_holes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff128_o[1:0] == '0) && (eff128_o[90:56] == '0) && (eff128_o[107:101] == '0) &&
        (eff128_o[114] == 1'b0) && (eff128_o[120:119] == '0) && (eff128_o[126:125] == '0));

    a_r7_fan64: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (eff64_o[49:18] == {32{rd_lo_o[17]}}) && (eff64_o[17:0] == rd_lo_o[17:0]) &&
        (eff64_o[63:50] == rd_lo_o[63:50]));

    a_r8_merge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        merge_o == ((merge_old_i & ~chk_sel) | (merge_new_i & chk_sel)));
endmodule

bind desc_mask_reg desc_mask_reg_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_wide_i(strap_wide_i),
    .lo_wr_i     (lo_wr_i),
    .full_wr_i   (full_wr_i),
    .wdata_i     (wdata_i),
    .rd_lo_o     (rd_lo_o),
    .rd_full_o   (rd_full_o),
    .eff64_o     (eff64_o),
    .eff128_o    (eff128_o),
    .merge_wide_i(merge_wide_i),
    .merge_old_i (merge_old_i),
    .merge_new_i (merge_new_i),
    .merge_o     (merge_o)
);

// File: tb/desc_mask_reg_bench.sv
`timescale 1ns/1ps
module desc_mask_reg_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wide = 1'b1, fa = 1'b1, fb = 1'b1;
    logic         lo_wr = 1'b0, full_wr = 1'b0;
    logic [127:0] wdata = '0;
    logic [63:0]  rd_lo, e64;
    logic [127:0] rd_full, e128, mg;
    logic         mwide = 1'b0;
    logic [127:0] mold = '0, mnew = '0;

    always #2 clk = ~clk;

    desc_mask_reg u_desc_mask_reg (
        .clk_i(clk), .rst_ni(rst_n),
        .strap_wide_i(wide), .strap_feat_a_i(fa), .strap_feat_b_i(fb),
        .lo_wr_i(lo_wr), .full_wr_i(full_wr), .wdata_i(wdata),
        .rd_lo_o(rd_lo), .rd_full_o(rd_full), .eff64_o(e64), .eff128_o(e128),
        .merge_wide_i(mwide), .merge_old_i(mold), .merge_new_i(mnew), .merge_o(mg)
    );

    typedef struct {
        logic [63:0]  lo;
        logic [127:0] full;
        logic [63:0]  e64;
        logic [127:0] e128;
        logic [127:0] mg;
        string        tag;
    } exp_t;

    exp_t         sbq[$];
    logic [127:0] model_q = '0;
    int           checks = 0;
    int           errors = 0;
    bit           done = 0;

    function automatic bit span(int n, int lo, int hi);
        return n >= lo && n <= hi;
    endfunction

    function automatic logic [127:0] writable(bit w, bit a, bit b);
        logic [127:0] m;
        for (int n = 0; n < 128; n++) begin
            m[n] = !(n == 0 || n == 52 || span(n, 18, 49));
            if (n >= 64)
                m[n] = w && !(span(n, 64, 90) || span(n, 101, 107) || n == 114 ||
                        span(n, 119, 120) || span(n, 125, 126)) &&
                       !(span(n, 121, 124) && !a) && !(n == 108 && !b);
        end
        return m;
    endfunction

    function automatic logic [127:0] exp_e128(logic [127:0] s, bit w, bit a, bit b);
        logic [127:0] m;
        for (int n = 0; n < 128; n++) begin
            m[n] = span(n, 17, 55) ? s[16] : s[n];
            if (span(n, 0, 1) || span(n, 56, 90) || span(n, 101, 107) || n == 114 ||
                span(n, 119, 120) || span(n, 125, 126)) m[n] = 1'b0;
            if (span(n, 121, 124) && !a) m[n] = 1'b0;
            if (n == 108 && !b) m[n] = 1'b0;
            if (!w) m[n] = 1'b0;
        end
        return m;
    endfunction

    function automatic logic [63:0] exp_e64(logic [127:0] s);
        logic [63:0] m;
        for (int n = 0; n < 64; n++) m[n] = span(n, 18, 49) ? s[17] : s[n];
        return m;
    endfunction

    task automatic push_exp(string tag);
        exp_t         e;
        logic [127:0] vis, sel;
        vis    = model_q & writable(wide, fa, fb);
        e.full = vis;
        e.lo   = vis[63:0];
        e.e128 = exp_e128(vis, wide, fa, fb);
        e.e64  = exp_e64(vis);
        sel    = mwide ? e.e128 : {64'b0, e.e64};
        e.mg   = (mold & ~sel) | (mnew & sel);
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    task automatic op(bit lo, bit full, logic [127:0] wd, bit mw,
                      logic [127:0] old, logic [127:0] nw, string tag);
        @(posedge clk); #1;
        lo_wr = lo; full_wr = full; wdata = wd; mwide = mw; mold = old; mnew = nw;
        @(posedge clk); #1;
        lo_wr = 1'b0; full_wr = 1'b0;
        if (full && wide) model_q = wd & writable(wide, fa, fb);
        else if (lo) model_q = {model_q[127:64], wd[63:0]} & writable(wide, fa, fb);
        push_exp(tag);
    endtask

    task automatic set_straps(bit w, bit a, bit b);
        @(posedge clk); #1;
        wide = w; fa = a; fb = b;
    endtask

    task automatic cmp(string tag, string fld, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
        end
    endtask

    // monitor: pops expected items late in each cycle
    initial begin
        forever begin
            @(posedge clk); #3;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                cmp(e.tag, "rd_lo", {64'b0, rd_lo}, {64'b0, e.lo});
                cmp(e.tag, "rd_full", rd_full, e.full);
                cmp(e.tag, "eff64", {64'b0, e64}, {64'b0, e.e64});
                cmp(e.tag, "eff128", e128, e.e128);
                cmp(e.tag, "merge", mg, e.mg);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    localparam logic [127:0] ONES = '1;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        push_exp("R9 reset clear");
        // R3 all-ones full write: reserved bits stay zero; R5/R6 follow
        op(0, 1, ONES, 1, '0, ONES, "R3 full ones");
        // R1 low write leaves upper half
        op(1, 0, '0, 0, ONES, '0, "R1 low zero keeps upper");
        // R5 R7 bit16=1 bit17=0 then reverse
        op(1, 0, 128'h0001_0000, 1, '0, ONES, "R5 bit16 set");
        op(1, 0, 128'h0002_0000, 0, '0, ONES, "R7 bit17 set");
        // R2 full write ignored without wide support
        set_straps(0, 1, 1);
        op(0, 1, ONES, 0, '0, ONES, "R2 full ignored narrow");
        op(1, 0, ONES, 1, ONES, '0, "R6 eff128 zero narrow");
        set_straps(1, 1, 1);
        // R2 priority when both writes
        op(1, 1, {64'hAAAA_5555_AAAA_5555, 64'h0F0F_0F0F_0F0F_0F0F}, 1, '0, ONES, "R2 full wins");
        // R4 feature straps off
        set_straps(1, 0, 0);
        op(0, 1, ONES, 1, '0, ONES, "R4 features absent");
        set_straps(1, 1, 0);
        op(0, 1, ONES, 1, '0, ONES, "R4 feat A only");
        set_straps(1, 0, 1);
        op(0, 1, ONES, 1, '0, ONES, "R4 feat B only");
        set_straps(1, 1, 1);
        // R8 merges in both widths
        op(0, 1, {64'h8123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211}, 0,
           {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, ONES, "R8 merge narrow");
        op(0, 0, '0, 1, {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888}, ONES, "R8 merge wide");
        for (int i = 0; i < 60; i++) begin
            logic [127:0] wd, od, nd;
            wd = {$urandom, $urandom, $urandom, $urandom};
            od = {$urandom, $urandom, $urandom, $urandom};
            nd = {$urandom, $urandom, $urandom, $urandom};
            if (i % 15 == 7) set_straps(1'($urandom), 1'($urandom), 1'($urandom));
            op(1'($urandom), 1'($urandom), wd, 1'($urandom), od, nd, "R8 random mix");
        end
        repeat (4) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule